// File: doc/BRIEF.md
# Serial Peripheral Slave Front End with Bus Pause

This block is the bus-facing half of a memory device that answers on a four-wire serial peripheral bus. The chip-select, serial clock, serial data-in and an active-low pause (hold) pin all arrive asynchronously. The block brings them into a faster system clock through synchronizer chains and detects their edges there. It gathers incoming bits into bytes for an instruction engine, most significant bit first. It shifts the engine's response bytes back out on a data pin that has its own output-enable.

The block accepts both idle levels of the serial clock: idle low (mode 0) and idle high (mode 3). Data is captured on rising edges and the output moves on falling edges. A pause request freezes the transfer in place without losing the bit position. After reset the slave responds only once it has seen chip-select go from high to low. When a frame closes, the block reports how many bits it counted and whether that count was a whole number of bytes, so the engine can discard a frame that stopped part-way through a byte.

The serial clock must run at no more than a quarter of the system clock.

Top module: `spi_hold_frontend`

## Requirements
- R1: While reset is held, `selected_o`, `miso_oe_o`, `hold_active_o`, `rx_valid_o`, `tx_load_o` and `frame_end_o` are all 0.
- R2: If chip-select is already low when reset is released, the block stays unselected. No byte is delivered and no frame report is produced until chip-select has gone high and then low again.
- R3: In both mode 0 and mode 3, data-in is captured on each rising serial clock edge and shifted in most significant bit first. After every eighth captured bit, `rx_valid_o` pulses for one system cycle with the assembled byte on `rx_byte_o`. In mode 3 the falling edge that starts a frame is not a data edge.
- R4: On the first falling edge after each completed byte, the block takes `tx_byte_i`, pulses `tx_load_o` for one cycle and drives bit 7 on `miso_o`. Each later falling edge moves one bit toward bit 0. During the first byte of a frame, `miso_o` is 0.
- R5: `miso_oe_o` is 1 only while the block is selected and not paused. Raising chip-select clears the bit position, so the next frame starts at bit 0.
- R6: When chip-select rises on a selected slave, `frame_end_o` pulses for one cycle. At the same time `frame_bits_o` gives the number of rising edges counted in the frame, and `frame_aligned_o` is 1 exactly when that number is a multiple of 8.
- R7: While the pause is in effect, `hold_active_o` is 1 and `miso_oe_o` is 0. Serial clock and data-in activity are ignored, and the transfer resumes at the same bit position once the pause is released.
- R8: A change on `hold_n_i` takes effect only while the synchronized serial clock is low. A change made while the clock is high waits until the clock next goes low.
- R9: Raising chip-select during a pause ends the frame (reported as in R6), clears the pause and clears the bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip-select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| mosi_i | input | 1 | Serial data into the slave |
| hold_n_i | input | 1 | Pause request, active low |
| miso_o | output | 1 | Serial data out of the slave |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| selected_o | output | 1 | Slave is selected |
| hold_active_o | output | 1 | Pause is in effect |
| rx_byte_o | output | BYTE_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_byte_o` |
| tx_byte_i | input | BYTE_W | Next response byte from the engine |
| tx_load_o | output | 1 | One-cycle strobe: `tx_byte_i` was taken |
| frame_end_o | output | 1 | One-cycle strobe on deselect |
| frame_bits_o | output | CNT_W | Bits counted in the closed frame |
| frame_aligned_o | output | 1 | Closed frame was a whole number of bytes |

## Verification
A change on a serial pin reaches the registered outputs three system cycles later: two synchronizer stages, then the registered edge decision. So `rx_valid_o`, `tx_load_o`, `miso_o`, `hold_active_o` and the frame report all settle by the third rising system edge after the pin moves. The bench holds every serial level for five system cycles and samples only at the end of each level, which is two cycles after the latest result is due. Received bytes and frame reports are captured by monitors at their strobes. The data-out pin is read just before the rising edge that a bus master would use. The deferral of a pause is checked by sampling `hold_active_o` one full level after `hold_n_i` changes while the clock is high, and again after the clock has gone low.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
   // serial clock edges qualified by selection and pause state
   typedef struct packed {
      logic rise;
      logic fall;
   } sck_edge_t;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
   parameter int WIDTH = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
   parameter int BYTE_W = 8,
   parameter int CNT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              rise,
   input  logic              din,
   output logic [BYTE_W-1:0] byte_o,
   output logic              valid_o,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam int IDX_W = $clog2(BYTE_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

   logic [BYTE_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr      <= '0;
         cnt_o   <= '0;
         byte_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (clr) begin
            sr    <= '0;
            cnt_o <= '0;
         end else if (rise) begin
            sr    <= {sr[BYTE_W-2:0], din};
            cnt_o <= cnt_o + 1'b1;
            if (cnt_o[IDX_W-1:0] == LAST_IDX) begin
               byte_o  <= {sr[BYTE_W-2:0], din};
               valid_o <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
   parameter int BYTE_W = 8,
   parameter int CNT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fall,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic              bit_o,
   output logic              load_o
);
   localparam int IDX_W = $clog2(BYTE_W);

   logic [BYTE_W-1:0] sr;
   logic              at_boundary;

   // a byte has just completed: count non-zero and on a byte edge
   assign at_boundary = (cnt_i != '0) && (cnt_i[IDX_W-1:0] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr     <= '0;
         load_o <= 1'b0;
      end else begin
         load_o <= 1'b0;
         if (clr) begin
            sr <= '0;
         end else if (fall) begin
            if (at_boundary) begin
               sr     <= byte_i;
               load_o <= 1'b1;
            end else begin
               sr <= {sr[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assign bit_o = sr[BYTE_W-1];
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
   import spi_fe_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CNT_W = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              sck_i,
   input  logic              mosi_i,
   input  logic              hold_n_i,
   output logic              miso_o,
   output logic              miso_oe_o,
   output logic              selected_o,
   output logic              hold_active_o,
   output logic [BYTE_W-1:0] rx_byte_o,
   output logic              rx_valid_o,
   input  logic [BYTE_W-1:0] tx_byte_i,
   output logic              tx_load_o,
   output logic              frame_end_o,
   output logic [CNT_W-1:0]  frame_bits_o,
   output logic              frame_aligned_o
);
   localparam int IDX_W = $clog2(BYTE_W);
   // synchronizer lanes: {hold_n, mosi, sck, cs_n}
   localparam logic [3:0] SYNC_RST = 4'b1000;

   if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_byte_w
      $error("BYTE_W must be a power of two of at least 2");
   end
   if (CNT_W <= IDX_W) begin : g_bad_cnt_w
      $error("CNT_W must exceed log2(BYTE_W)");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [3:0] sync_q;
   logic       cs_s, sck_s, mosi_s, hold_s;
   logic       cs_p, sck_p, sel_q, held_q;
   logic       clr, active;
   sck_edge_t  edge_c;
   logic [CNT_W-1:0] bit_cnt;

   // chip-select lane resets low, so a low level at reset never looks like a fall
   spi_fe_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({hold_n_i, mosi_i, sck_i, cs_n_i}),
      .q    (sync_q)
   );
   assign {hold_s, mosi_s, sck_s, cs_s} = sync_q;

   assign clr         = cs_s | ~sel_q;
   assign active      = ~clr & ~held_q;
   assign edge_c.rise = active & sck_s & ~sck_p;
   assign edge_c.fall = active & ~sck_s & sck_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_p            <= 1'b0;
         sck_p           <= 1'b0;
         sel_q           <= 1'b0;
         held_q          <= 1'b0;
         frame_end_o     <= 1'b0;
         frame_bits_o    <= '0;
         frame_aligned_o <= 1'b0;
      end else begin
         cs_p        <= cs_s;
         sck_p       <= sck_s;
         frame_end_o <= 1'b0;
         if (cs_p && !cs_s)  sel_q <= 1'b1;
         else if (cs_s)      sel_q <= 1'b0;
         if (sel_q && cs_s) begin
            frame_end_o     <= 1'b1;
            frame_bits_o    <= bit_cnt;
            frame_aligned_o <= (bit_cnt[IDX_W-1:0] == '0);
         end
         // pause follows the pin only while the serial clock is low
         if (clr)         held_q <= 1'b0;
         else if (!sck_s) held_q <= ~hold_s;
      end
   end

   spi_fe_rx #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .rise   (edge_c.rise),
      .din    (mosi_s),
      .byte_o (rx_byte_o),
      .valid_o(rx_valid_o),
      .cnt_o  (bit_cnt)
   );

   spi_fe_tx #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .fall  (edge_c.fall),
      .cnt_i (bit_cnt),
      .byte_i(tx_byte_i),
      .bit_o (miso_o),
      .load_o(tx_load_o)
   );

   assign selected_o    = sel_q;
   assign hold_active_o = held_q;
   assign miso_oe_o     = sel_q & ~held_q;
endmodule

// File: rtl/spi_hold_frontend_chk.sv
module spi_hold_frontend_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sck_s,
   input logic              selected_o,
   input logic              hold_active_o,
   input logic              miso_oe_o,
   input logic              miso_o,
   input logic              tx_load_o,
   input logic [BYTE_W-1:0] tx_byte_i,
   input logic              rx_valid_o,
   input logic              frame_end_o
);
   // R7
   hold_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active_o |-> !miso_oe_o);

   // R5
   desel_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !selected_o |-> !miso_oe_o);

   // R8
   hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_active_o) |-> !$past(sck_s));

   // R4
   tx_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load_o |-> (miso_o == $past(tx_byte_i[BYTE_W-1])));

   // R6
   frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end_o |-> !selected_o);

   // R3
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);
endmodule

bind spi_hold_frontend spi_hold_frontend_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sck_s        (sck_s),
   .selected_o   (selected_o),
   .hold_active_o(hold_active_o),
   .miso_oe_o    (miso_oe_o),
   .miso_o       (miso_o),
   .tx_load_o    (tx_load_o),
   .tx_byte_i    (tx_byte_i),
   .rx_valid_o   (rx_valid_o),
   .frame_end_o  (frame_end_o)
);

// File: tb/spi_hold_frontend_test.sv
module spi_hold_frontend_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF = 5;
   localparam int BYTE_W = 8;
   localparam int CNT_W = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b0;
   logic sck = 1'b0;
   logic mosi = 1'b0;
   logic hold_n = 1'b1;
   logic [BYTE_W-1:0] tx_byte;
   logic miso_o, miso_oe_o, selected_o, hold_active_o;
   logic [BYTE_W-1:0] rx_byte_o;
   logic rx_valid_o, tx_load_o, frame_end_o, frame_aligned_o;
   logic [CNT_W-1:0] frame_bits_o;

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_hold_frontend #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .mosi_i(mosi),
      .hold_n_i(hold_n), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
      .selected_o(selected_o), .hold_active_o(hold_active_o),
      .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o), .tx_byte_i(tx_byte),
      .tx_load_o(tx_load_o), .frame_end_o(frame_end_o),
      .frame_bits_o(frame_bits_o), .frame_aligned_o(frame_aligned_o)
   );

   function automatic logic [7:0] resp_pat(int i);
      return 8'(32'hC3 ^ (i * 29));
   endfunction

   // engine model: next response byte advances on each load strobe
   int tx_idx = 0;
   always @(posedge clk) begin
      if (!selected_o) tx_idx <= 0;
      else if (tx_load_o) tx_idx <= tx_idx + 1;
   end
   assign tx_byte = resp_pat(tx_idx);

   // monitors
   logic [7:0] rx_log [64];
   int rx_n = 0;
   int fe_n = 0;
   int fe_bits = 0;
   bit fe_al = 0;
   always @(posedge clk) begin
      if (rx_valid_o) begin
         rx_log[rx_n % 64] <= rx_byte_o;
         rx_n <= rx_n + 1;
      end
      if (frame_end_o) begin
         fe_n <= fe_n + 1;
         fe_bits <= int'(frame_bits_o);
         fe_al <= frame_aligned_o;
      end
   end

   task automatic check_eq(string req, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic report;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   task automatic wait_half;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic frame_open(bit mode3);
      sck = mode3;
      wait_half();
      cs_n = 1'b0;
      wait_half();
   endtask

   task automatic clk_bit(bit b, output bit q);
      sck = 1'b0;
      mosi = b;
      wait_half();
      q = miso_o;
      sck = 1'b1;
      wait_half();
   endtask

   task automatic frame_close(bit mode3);
      if (!mode3) begin
         sck = 1'b0;
         wait_half();
      end
      cs_n = 1'b1;
      wait_half();
      wait_half();
   endtask

   task automatic full_frame(bit mode3, int nbytes, int seed);
      int base = rx_n;
      int fe0 = fe_n;
      bit q;
      frame_open(mode3);
      check_eq("R5", "oe while selected", int'(miso_oe_o), 1);
      for (int j = 0; j < nbytes; j++) begin
         logic [7:0] d = 8'(seed * 53 + j * 17 + 1);
         logic [7:0] got = '0;
         logic [7:0] exp_q = (j == 0) ? 8'h00 : resp_pat(j - 1);
         for (int b = 7; b >= 0; b--) begin
            clk_bit(d[b], q);
            got[b] = q;
         end
         check_eq("R4", "miso byte", int'(got), int'(exp_q));
         wait_half();
         sck = mode3 ? 1'b1 : 1'b0;
         check_eq("R3", "rx byte", int'(rx_log[(base + j) % 64]), int'(d));
      end
      frame_close(mode3);
      check_eq("R3", "byte count", rx_n - base, nbytes);
      check_eq("R6", "frame end count", fe_n - fe0, 1);
      check_eq("R6", "frame bits", fe_bits, nbytes * 8);
      check_eq("R6", "aligned", int'(fe_al), 1);
      check_eq("R5", "oe after deselect", int'(miso_oe_o), 0);
   endtask

   initial begin
      bit q;
      int base, fe0;
      logic [7:0] d;
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      check_eq("R1", "selected in reset", int'(selected_o), 0);
      check_eq("R1", "oe in reset", int'(miso_oe_o), 0);
      check_eq("R1", "hold in reset", int'(hold_active_o), 0);
      check_eq("R1", "strobes in reset", int'({rx_valid_o, tx_load_o, frame_end_o}), 0);
      rst_n = 1'b1;
      wait_half();

      // R2: chip-select low through reset must not select
      base = rx_n;
      fe0 = fe_n;
      d = 8'hA5;
      for (int b = 7; b >= 0; b--) clk_bit(d[b], q);
      sck = 1'b0;
      wait_half();
      check_eq("R2", "selected without fall", int'(selected_o), 0);
      check_eq("R2", "bytes without fall", rx_n - base, 0);
      cs_n = 1'b1;
      wait_half();
      wait_half();
      check_eq("R2", "no frame report", fe_n - fe0, 0);

      // R3/R4 sweep over both clock idle levels and frame lengths
      for (int m = 0; m < 2; m++)
         for (int n = 1; n <= 4; n++)
            full_frame(bit'(m), n, m * 7 + n);

      // R6 partial frames
      for (int m = 0; m < 2; m++)
         for (int nb = 1; nb <= 17; nb++) begin
            fe0 = fe_n;
            frame_open(bit'(m));
            for (int b = 0; b < nb; b++) clk_bit(bit'((b * 3 + nb) & 1), q);
            frame_close(bit'(m));
            check_eq("R6", "partial frame count", fe_n - fe0, 1);
            check_eq("R6", "partial bits", fe_bits, nb);
            check_eq("R6", "partial aligned", int'(fe_al), int'(nb % 8 == 0));
         end

      // R7 pause in the middle of a byte
      base = rx_n;
      frame_open(1'b0);
      d = 8'h9A;
      for (int b = 7; b >= 3; b--) clk_bit(d[b], q);
      sck = 1'b0;
      wait_half();
      hold_n = 1'b0;
      wait_half();
      check_eq("R7", "hold active", int'(hold_active_o), 1);
      check_eq("R7", "oe during hold", int'(miso_oe_o), 0);
      for (int k = 0; k < 6; k++) begin
         sck = 1'b1; mosi = bit'(k & 1);
         wait_half();
         sck = 1'b0;
         wait_half();
      end
      check_eq("R7", "no bytes during hold", rx_n - base, 0);
      hold_n = 1'b1;
      wait_half();
      check_eq("R7", "hold released", int'(hold_active_o), 0);
      check_eq("R7", "oe restored", int'(miso_oe_o), 1);
      for (int b = 2; b >= 0; b--) clk_bit(d[b], q);
      d = 8'h3C;
      for (int b = 7; b >= 0; b--) clk_bit(d[b], q);
      frame_close(1'b0);
      check_eq("R7", "byte across hold", int'(rx_log[base % 64]), 32'h9A);
      check_eq("R7", "byte after hold", int'(rx_log[(base + 1) % 64]), 32'h3C);
      check_eq("R7", "bits across hold", fe_bits, 16);

      // R8 pause changes requested while clock is high are deferred
      base = rx_n;
      frame_open(1'b0);
      d = 8'h5E;
      for (int b = 7; b >= 4; b--) clk_bit(d[b], q);
      hold_n = 1'b0;
      wait_half();
      check_eq("R8", "hold deferred while high", int'(hold_active_o), 0);
      sck = 1'b0;
      wait_half();
      check_eq("R8", "hold after clock low", int'(hold_active_o), 1);
      sck = 1'b1;
      wait_half();
      hold_n = 1'b1;
      wait_half();
      check_eq("R8", "release deferred while high", int'(hold_active_o), 1);
      sck = 1'b0;
      wait_half();
      check_eq("R8", "release after clock low", int'(hold_active_o), 0);
      for (int b = 3; b >= 0; b--) clk_bit(d[b], q);
      frame_close(1'b0);
      check_eq("R8", "byte with deferred hold", int'(rx_log[base % 64]), 32'h5E);
      check_eq("R8", "bits with deferred hold", fe_bits, 8);

      // R9 deselect during a pause
      fe0 = fe_n;
      frame_open(1'b0);
      for (int b = 0; b < 5; b++) clk_bit(1'b1, q);
      sck = 1'b0;
      wait_half();
      hold_n = 1'b0;
      wait_half();
      cs_n = 1'b1;
      wait_half();
      wait_half();
      check_eq("R9", "frame report count", fe_n - fe0, 1);
      check_eq("R9", "bits at deselect", fe_bits, 5);
      check_eq("R9", "aligned at deselect", int'(fe_al), 0);
      check_eq("R9", "hold cleared", int'(hold_active_o), 0);
      check_eq("R9", "deselected", int'(selected_o), 0);
      hold_n = 1'b1;
      base = rx_n;
      frame_open(1'b0);
      d = 8'h71;
      for (int b = 7; b >= 0; b--) clk_bit(d[b], q);
      frame_close(1'b0);
      check_eq("R9", "fresh byte after reset", int'(rx_log[base % 64]), 32'h71);
      check_eq("R9", "fresh frame bits", fe_bits, 8);

      done = 1;
      report();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         vectors++;
         fails++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         report();
         $finish;
      end
   end
endmodule